// File: doc/BRIEF.md
# ADC Channel Sequencing Controller

This block sets the order in which analog inputs reach the sample/hold channels and the order in which those channels go to one shared converter. A sample-start request opens acquisition. A conversion trigger closes it. The block then sends single-cycle convert-start pulses, each tagged with a channel index, and waits for the converter's done pulse after each one. The converter itself, the result buffer and acquisition timing are outside the block.

Each sequence covers one, two or four sample/hold channels. In sequential mode every channel is acquired and converted in turn, and each channel needs its own trigger. In simultaneous mode all selected channels are acquired on one trigger and then converted one after another. Input selection for channel 0 works as follows:
- It can alternate between a primary input set and a secondary input set from one sequence to the next.
- While the primary set is active, it can step upward through the inputs marked in a 16-bit scan mask.
- An interrupt-boundary pulse from the buffer controller sends selection back to the primary set and back to the start of the scan.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, `sh_en` is 0, `conv_start` is 0 and channel 0 uses the primary set with the scan at its start.
- R2: `cfg_nch` is captured at sequence start. 2'b00 selects 1 channel, 2'b01 selects 2 channels, and 2'b10 or 2'b11 selects 4 channels. The sequence converts `conv_ch` = 0, 1, … up to count−1 and then goes idle with `sh_en` = 0.
- R3: With `cfg_simul` = 0, channel k is sampled alone (`sh_en` = 1<<k). Each channel needs its own `conv_trig`. After a channel's `conv_done` the block returns to sampling the next channel.
- R4: With `cfg_simul` = 1, all selected channels are enabled together (`sh_en` = (1<<count)−1) until one trigger. The conversions then follow one after another, each started by the previous `conv_done`. With one channel the mode makes no difference.
- R5: `conv_start` lasts one cycle and comes one cycle after the `conv_trig` or `conv_done` that caused it. `sh_en` is 0 while it is high. No further pulse comes before `conv_done`.
- R6: With `cfg_alt` = 0, channel 0 always uses the primary set. With `cfg_alt` = 1, sequences use the primary set, then the secondary set (`cfg_muxb_sel`), and keep alternating.
- R7: An `irq_bound` pulse returns the alternation to the primary set and restarts the scan at the lowest marked input.
- R8: With `cfg_scan_en` = 1 and a nonzero mask, each primary-set sequence moves channel 0 to the next marked input above the previous one. After the highest marked input it wraps to the lowest. Secondary-set sequences neither use nor advance the scan.
- R9: With scanning off, or with an all-zero mask, primary-set sequences use `cfg_muxa_sel`. `ch0_input` holds steady for the whole sequence.
- R10: `conv_trig` is ignored when not sampling. `conv_done` is ignored when not waiting. `samp_req` is ignored while a sequence runs.
- R11: If `cfg_nch` or `cfg_simul` changes during a sequence, that sequence is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_req | input | 1 | Sample-start request pulse |
| conv_trig | input | 1 | Ends acquisition, starts conversion |
| conv_done | input | 1 | Converter finished current channel |
| irq_bound | input | 1 | Interrupt-boundary pulse |
| cfg_nch | input | 2 | Channel count code |
| cfg_simul | input | 1 | Simultaneous sampling mode |
| cfg_alt | input | 1 | Alternate primary/secondary input sets |
| cfg_scan_en | input | 1 | Channel-0 scan enable |
| cfg_scan_mask | input | 16 | Inputs marked for scanning |
| cfg_muxa_sel | input | 4 | Primary-set input for channel 0 |
| cfg_muxb_sel | input | 4 | Secondary-set input for channel 0 |
| sh_en | output | 4 | Sample/hold enable per channel |
| ch0_input | output | 4 | Input number routed to channel 0 |
| conv_ch | output | 2 | Channel being converted |
| conv_start | output | 1 | Convert-start pulse |

## Verification
The checker relies on three conditions about the inputs:
- The input-select fields, scan enable, mask and alternate mode stay constant while a sequence runs.
- `irq_bound` arrives only while the block is idle.
- `conv_done` is answered only after a `conv_start`.

The bench respects all three. It changes those fields and pulses the boundary only between sequences, and the converter model returns done one cycle after each convert-start has been seen. Only channel count and simultaneous mode are changed inside a sequence, and only to check that they were captured at sequence start. Stray triggers, dones and requests are sent only in states where they must be ignored.

// File: rtl/adc_seq_pkg.sv
// Shared types and helpers for the ADC channel sequencer.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_CONV   = 2'd2,
        ST_WAIT   = 2'd3
    } seq_state_t;

    // Decode the channel-count code into a channel count (1, 2 or 4).
    function automatic logic [2:0] nch_count(input logic [1:0] code);
        case (code)
            2'b00:   return 3'd1;
            2'b01:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/adc_seq_fsm.sv
// Acquire/convert sequencer. Captures channel count and simultaneous mode
// at sequence start, drives sample/hold enables, and issues one convert-start
// per channel in ascending order, each gated by converter done.
// Assumes NUM_SH is 4 (count codes decode to 1, 2 or 4 channels).
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NUM_SH = 4,
    localparam int CH_W  = $clog2(NUM_SH),
    localparam int CNT_W = CH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_req,
    input  logic              conv_trig,
    input  logic              conv_done,
    input  logic [1:0]        cfg_nch,
    input  logic              cfg_simul,
    output logic [NUM_SH-1:0] sh_en,
    output logic [CH_W-1:0]   conv_ch,
    output logic              conv_start,
    output logic              seq_end,
    output logic              busy
);

    seq_state_t        st;
    logic [CNT_W-1:0]  n_q;
    logic              simul_q;
    logic [CH_W-1:0]   k_q;
    logic [NUM_SH-1:0] sel_mask;
    logic              last_ch;

    // Channels enabled by the captured count.
    for (genvar i = 0; i < NUM_SH; i++) begin : g_sel
        assign sel_mask[i] = (CNT_W'(i) < n_q);
    end

    assign last_ch = (CNT_W'(k_q) == n_q - CNT_W'(1));

    // State, channel index and captured configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            n_q     <= CNT_W'(1);
            simul_q <= 1'b0;
            k_q     <= '0;
        end else begin
            case (st)
                ST_IDLE: if (samp_req) begin
                    n_q     <= CNT_W'(nch_count(cfg_nch));
                    simul_q <= cfg_simul;
                    k_q     <= '0;
                    st      <= ST_SAMPLE;
                end
                ST_SAMPLE: if (conv_trig) st <= ST_CONV;
                ST_CONV:   st <= ST_WAIT;
                ST_WAIT: if (conv_done) begin
                    if (last_ch) begin
                        st <= ST_IDLE;
                    end else begin
                        k_q <= k_q + CH_W'(1);
                        st  <= simul_q ? ST_CONV : ST_SAMPLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Sample/hold enables: all selected together, or the current one alone.
    always_comb begin
        sh_en = '0;
        if (st == ST_SAMPLE)
            sh_en = simul_q ? sel_mask : (NUM_SH'(1) << k_q);
    end

    assign conv_start = (st == ST_CONV);
    assign conv_ch    = k_q;
    assign seq_end    = (st == ST_WAIT) && conv_done && last_ch;
    assign busy       = (st != ST_IDLE);

endmodule

// File: rtl/adc_seq_chsel.sv
// Channel-0 input selector. Tracks primary/secondary alternation and the
// ascending scan position; both update at sequence end and restart at the
// interrupt boundary, which takes priority. Assumes selects stay constant
// within a sequence.
module adc_seq_chsel #(
    parameter int NUM_INPUTS = 16,
    localparam int IN_W      = $clog2(NUM_INPUTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  seq_end,
    input  logic                  irq_bound,
    input  logic                  cfg_alt,
    input  logic                  cfg_scan_en,
    input  logic [NUM_INPUTS-1:0] cfg_scan_mask,
    input  logic [IN_W-1:0]       cfg_muxa_sel,
    input  logic [IN_W-1:0]       cfg_muxb_sel,
    output logic [IN_W-1:0]       ch0_input
);

    logic            alt_b;
    logic            restart;
    logic [IN_W-1:0] scan_cur;
    logic [IN_W-1:0] low_idx;
    logic [IN_W-1:0] eff_idx;
    logic [IN_W-1:0] next_idx;
    logic            scan_live;

    assign scan_live = cfg_scan_en && (|cfg_scan_mask);

    // Lowest marked input.
    always_comb begin
        low_idx = '0;
        for (int i = NUM_INPUTS - 1; i >= 0; i--)
            if (cfg_scan_mask[i]) low_idx = IN_W'(i);
    end

    assign eff_idx = restart ? low_idx : scan_cur;

    // Next marked input above the current one, wrapping to the lowest.
    always_comb begin
        next_idx = low_idx;
        for (int i = NUM_INPUTS - 1; i >= 0; i--)
            if (cfg_scan_mask[i] && (i > int'(eff_idx))) next_idx = IN_W'(i);
    end

    // Alternation phase and scan position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alt_b    <= 1'b0;
            restart  <= 1'b1;
            scan_cur <= '0;
        end else if (irq_bound) begin
            alt_b   <= 1'b0;
            restart <= 1'b1;
        end else if (seq_end) begin
            alt_b <= cfg_alt ? ~alt_b : 1'b0;
            if (!alt_b && scan_live) begin
                scan_cur <= next_idx;
                restart  <= 1'b0;
            end
        end
    end

    // Route channel 0 from the active set.
    always_comb begin
        if (alt_b)          ch0_input = cfg_muxb_sel;
        else if (scan_live) ch0_input = eff_idx;
        else                ch0_input = cfg_muxa_sel;
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the ADC channel sequencer: joins the acquire/convert sequencer with
// the channel-0 input selector. Assumes an external converter that answers
// each convert-start with one done pulse.
module adc_seq_ctrl #(
    parameter int NUM_INPUTS = 16,
    parameter int NUM_SH     = 4,
    localparam int IN_W      = $clog2(NUM_INPUTS),
    localparam int CH_W      = $clog2(NUM_SH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  samp_req,
    input  logic                  conv_trig,
    input  logic                  conv_done,
    input  logic                  irq_bound,
    input  logic [1:0]            cfg_nch,
    input  logic                  cfg_simul,
    input  logic                  cfg_alt,
    input  logic                  cfg_scan_en,
    input  logic [NUM_INPUTS-1:0] cfg_scan_mask,
    input  logic [IN_W-1:0]       cfg_muxa_sel,
    input  logic [IN_W-1:0]       cfg_muxb_sel,
    output logic [NUM_SH-1:0]     sh_en,
    output logic [IN_W-1:0]       ch0_input,
    output logic [CH_W-1:0]       conv_ch,
    output logic                  conv_start
);

    logic seq_end;
    logic seq_busy;

    adc_seq_fsm #(.NUM_SH(NUM_SH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_req   (samp_req),
        .conv_trig  (conv_trig),
        .conv_done  (conv_done),
        .cfg_nch    (cfg_nch),
        .cfg_simul  (cfg_simul),
        .sh_en      (sh_en),
        .conv_ch    (conv_ch),
        .conv_start (conv_start),
        .seq_end    (seq_end),
        .busy       (seq_busy)
    );

    adc_seq_chsel #(.NUM_INPUTS(NUM_INPUTS)) u_chsel (
        .clk           (clk),
        .rst_n         (rst_n),
        .seq_end       (seq_end),
        .irq_bound     (irq_bound),
        .cfg_alt       (cfg_alt),
        .cfg_scan_en   (cfg_scan_en),
        .cfg_scan_mask (cfg_scan_mask),
        .cfg_muxa_sel  (cfg_muxa_sel),
        .cfg_muxb_sel  (cfg_muxb_sel),
        .ch0_input     (ch0_input)
    );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Protocol checker for the ADC channel sequencer, bound to the top.
// Assumes selects are constant within a sequence and the boundary pulse
// arrives only while idle.
module adc_seq_ctrl_chk #(
    parameter int NUM_SH = 4,
    parameter int IN_W   = 4,
    parameter int CH_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              samp_req,
    input logic              conv_trig,
    input logic              conv_done,
    input logic [NUM_SH-1:0] sh_en,
    input logic [IN_W-1:0]   ch0_input,
    input logic [CH_W-1:0]   conv_ch,
    input logic              conv_start,
    input logic              busy
);

    // R5
    conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R5
    conv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ($past(conv_trig) || $past(conv_done)));

    // R5
    sh_conv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (sh_en == '0));

    // R3 R4
    sh_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot0(sh_en) || (sh_en == NUM_SH'(3)) || (sh_en == NUM_SH'(15))));

    // R9
    ch0_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ch0_input));

    // R10
    idle_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && conv_trig) |=> !conv_start);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .NUM_SH (NUM_SH),
    .IN_W   (IN_W),
    .CH_W   (CH_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_req   (samp_req),
    .conv_trig  (conv_trig),
    .conv_done  (conv_done),
    .sh_en      (sh_en),
    .ch0_input  (ch0_input),
    .conv_ch    (conv_ch),
    .conv_start (conv_start),
    .busy       (seq_busy)
);

// File: tb/adc_seq_ctrl_tb.sv
// Self-checking bench: sweeps count/mode combinations, alternation, scanning,
// boundary restarts and ignored inputs against a behavioural reference.
module adc_seq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        samp_req, conv_trig, conv_done, irq_bound;
    logic [1:0]  cfg_nch;
    logic        cfg_simul, cfg_alt, cfg_scan_en;
    logic [15:0] cfg_scan_mask;
    logic [3:0]  cfg_muxa_sel, cfg_muxb_sel;
    logic [3:0]  sh_en;
    logic [3:0]  ch0_input;
    logic [1:0]  conv_ch;
    logic        conv_start;

    int tests = 0;
    int fails = 0;

    // Reference model of channel-0 selection.
    bit       m_alt_b;
    bit       m_restart;
    int       m_cur;

    always #10 clk = ~clk;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .samp_req(samp_req), .conv_trig(conv_trig),
        .conv_done(conv_done), .irq_bound(irq_bound), .cfg_nch(cfg_nch),
        .cfg_simul(cfg_simul), .cfg_alt(cfg_alt), .cfg_scan_en(cfg_scan_en),
        .cfg_scan_mask(cfg_scan_mask), .cfg_muxa_sel(cfg_muxa_sel),
        .cfg_muxb_sel(cfg_muxb_sel), .sh_en(sh_en), .ch0_input(ch0_input),
        .conv_ch(conv_ch), .conv_start(conv_start)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lowest(input logic [15:0] m);
        for (int i = 0; i < 16; i++) if (m[i]) return i;
        return 0;
    endfunction

    function automatic int next_after(input logic [15:0] m, input int c);
        for (int i = c + 1; i < 16; i++) if (m[i]) return i;
        return lowest(m);
    endfunction

    function automatic int exp_ch0();
        if (m_alt_b) return int'(cfg_muxb_sel);
        if (cfg_scan_en && cfg_scan_mask != 0)
            return m_restart ? lowest(cfg_scan_mask) : m_cur;
        return int'(cfg_muxa_sel);
    endfunction

    task automatic pulse_samp(); samp_req = 1; @(negedge clk); samp_req = 0; endtask
    task automatic pulse_trig(); conv_trig = 1; @(negedge clk); conv_trig = 0; endtask
    task automatic pulse_done(); conv_done = 1; @(negedge clk); conv_done = 0; endtask

    task automatic pulse_irq();
        irq_bound = 1; @(negedge clk); irq_bound = 0;
        m_alt_b = 0; m_restart = 1;
    endtask

    // One full sequence; flip changes count/mode mid-run, poke sends stray inputs.
    task automatic run_seq(input int code, input bit sim, input bit flip, input bit poke);
        int n = (code == 0) ? 1 : (code == 1) ? 2 : 4;
        int e = exp_ch0();
        cfg_nch = 2'(code); cfg_simul = sim;
        pulse_samp();
        if (flip) begin cfg_nch = 2'd0; cfg_simul = ~sim; end
        chk("R6/R8/R9 ch0_input", int'(ch0_input), e);
        if (sim) begin
            chk("R4 simultaneous sh_en", int'(sh_en), (1 << n) - 1);
            pulse_trig();
            for (int k = 0; k < n; k++) begin
                chk("R5 conv_start", int'(conv_start), 1);
                chk("R2 conv_ch order", int'(conv_ch), k);
                @(negedge clk);
                chk("R5 single pulse", int'(conv_start), 0);
                chk("R9 ch0 hold", int'(ch0_input), e);
                pulse_done();
            end
        end else begin
            for (int k = 0; k < n; k++) begin
                chk("R3 sequential sh_en", int'(sh_en), 1 << k);
                if (poke && k > 0) begin
                    pulse_samp();
                    chk("R10 samp_req ignored", int'(sh_en), 1 << k);
                end
                pulse_trig();
                chk("R5 conv_start", int'(conv_start), 1);
                chk("R2 conv_ch order", int'(conv_ch), k);
                @(negedge clk);
                if (poke) begin
                    pulse_trig();
                    chk("R10 trig in wait ignored", int'(conv_start), 0);
                end
                pulse_done();
            end
        end
        chk("R2 idle after last", int'(sh_en), 0);
        chk("R2 no extra start", int'(conv_start), 0);
        if (!m_alt_b && cfg_scan_en && cfg_scan_mask != 0) begin
            m_cur = next_after(cfg_scan_mask, e);
            m_restart = 0;
        end
        m_alt_b = cfg_alt ? !m_alt_b : 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 0; samp_req = 0; conv_trig = 0; conv_done = 0; irq_bound = 0;
        cfg_nch = 0; cfg_simul = 0; cfg_alt = 0; cfg_scan_en = 0;
        cfg_scan_mask = 16'h0; cfg_muxa_sel = 4'd3; cfg_muxb_sel = 4'd9;
        m_alt_b = 0; m_restart = 1; m_cur = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset sh_en", int'(sh_en), 0);
        chk("R1 reset conv_start", int'(conv_start), 0);
        chk("R1 reset ch0", int'(ch0_input), 3);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after reset sh_en", int'(sh_en), 0);
        chk("R1 after reset ch0", int'(ch0_input), 3);

        // R10: stray trigger and done while idle
        pulse_trig();
        chk("R10 idle trig ignored", int'(conv_start), 0);
        pulse_done();
        chk("R10 idle done ignored", int'(sh_en), 0);

        // R2 R3 R4: sweep every count code and both modes
        for (int c = 0; c < 4; c++)
            for (int s = 0; s < 2; s++)
                run_seq(c, s[0], 1'b0, 1'b0);

        // R10: stray inputs inside a sequential run
        run_seq(2, 1'b0, 1'b0, 1'b1);

        // R11: count and mode captured at start
        run_seq(2, 1'b0, 1'b1, 1'b0);
        run_seq(1, 1'b1, 1'b1, 1'b0);
        cfg_nch = 0; cfg_simul = 0;

        // R6: alternation over several sequences, then R7 restart
        cfg_alt = 1;
        for (int q = 0; q < 5; q++) run_seq(q % 3, q[0], 1'b0, 1'b0);
        pulse_irq();
        chk("R7 irq returns to primary", int'(ch0_input), 3);
        run_seq(0, 1'b0, 1'b0, 1'b0);
        cfg_alt = 0;
        pulse_irq();

        // R8: scan through marked inputs 4, 7, 10, 13 with wrap
        cfg_scan_en = 1; cfg_scan_mask = 16'h2490;
        for (int q = 0; q < 6; q++) run_seq(q % 3, 1'b1, 1'b0, 1'b0);
        pulse_irq();
        chk("R7 scan restart", int'(ch0_input), 4);

        // R8 with R6: secondary sequences do not advance the scan
        cfg_alt = 1;
        for (int q = 0; q < 6; q++) run_seq(1, 1'b0, 1'b0, 1'b0);
        cfg_alt = 0;
        pulse_irq();

        // R8: single marked input at the top end
        cfg_scan_mask = 16'h8000;
        for (int q = 0; q < 3; q++) run_seq(0, 1'b0, 1'b0, 1'b0);

        // R9: all-zero mask falls back to primary select
        cfg_scan_mask = 16'h0000; cfg_muxa_sel = 4'd12;
        pulse_irq();
        for (int q = 0; q < 2; q++) run_seq(2, 1'b1, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule